// File: doc/BRIEF.md
# Thresholded Edge-Detecting Event Counter

This block counts occurrences of one hardware event, chosen by a 32-bit control word that it holds itself. In every clock cycle the event source presents eight sub-event lanes for the selected event, together with the current privilege level. The block keeps only the lanes enabled by the unit mask and adds up the set bits. It then checks whether counting is allowed at that privilege level and whether the global enable is set. From there it works in one of three ways. It can add the full per-cycle occurrence count. It can add one in each cycle where the count passes a programmable threshold. It can add one only when that threshold condition rises from false to true.

The counter is 40 bits wide and can be loaded directly. When it wraps past its top value and the overflow-interrupt bit is set, a sticky interrupt request goes high. The request stays high until a write-one-to-clear pulse arrives. Three pieces of control sit alongside the datapath. A two-state machine follows the previous value of the qualified condition for edge counting. A two-state machine holds the interrupt request. A registered qualification stage separates the lane reduction from the compare and add.

Named states and transitions:

- **Condition tracker:**
  - `COND_LOW` goes to `COND_HIGH` when the qualified condition is true ("rise").
  - `COND_HIGH` goes to `COND_LOW` when it is false ("fall").
  - Otherwise the tracker stays where it is.
- **Interrupt machine:**
  - `IRQ_IDLE` goes to `IRQ_PENDING` on an overflow while the interrupt enable is set ("raise").
  - `IRQ_PENDING` goes to `IRQ_IDLE` on a clear pulse when no new overflow happens in the same cycle ("clear").

Top module: `evc_counter_top`

## Requirements
- R1: After reset, `cfg_q` reads 0x0041_0000, which means only bit 16 (user enable) and bit 22 (global enable) are set. At the same time `count` is 0 and `irq` is 0.
- R2: A `cfg_we` pulse stores `cfg_wdata` into the control word. The fields are:
  - [7:0] event select
  - [15:8] unit mask
  - [16] user enable
  - [17] OS enable
  - [18] edge detect
  - [19] pin control
  - [20] overflow-interrupt enable
  - [21] reserved, which always reads 0
  - [22] global enable
  - [23] invert
  - [31:24] threshold mask

  All bits other than bit 21 read back exactly as written.
- R3: The per-cycle occurrence count is the number of set bits in `sub_hits & unit_mask`, which ranges from 0 to 8. Inputs sampled at one rising edge reach `count` at the following rising edge.
- R4: Counting is allowed at privilege 1, 2 or 3 only when the user enable is set, and at privilege 0 only when the OS enable is set. In any other cycle nothing is counted.
- R5: When the threshold mask is 0 and edge detect is clear, the counter adds the full occurrence count. In that case the invert bit has no effect.
- R6: When the threshold mask is nonzero and edge detect is clear, the counter adds 1 in each qualified cycle where count ≥ mask. If invert is set, it adds 1 where count < mask instead. It never adds more than 1 per cycle.
- R7: When edge detect is set, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. The qualified condition is the threshold compare when the mask is nonzero, and count ≠ 0 when the mask is zero.
- R8: While the global enable is clear, `count` holds its value and is not cleared.
- R9: A `cnt_we` pulse loads `cnt_wdata` into the counter. A load takes priority over an increment in the same cycle.
- R10: The counter wraps modulo 2^40. If the interrupt enable is set, a wrap sets `irq`, and `irq` then stays set. A wrap with the interrupt enable clear leaves `irq` low.
- R11: An `irq_clr` pulse clears `irq`. If an overflow and a clear pulse occur in the same cycle, the overflow wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_q | output | 32 | Current control word |
| sub_hits | input | 8 | Sub-event lanes of the selected event for this cycle |
| priv | input | 2 | Current privilege level, 0 = OS |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| count | output | CNT_W | Counter value |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt request |
| irq | output | 1 | Sticky overflow interrupt request |

## Verification
The assertions check several properties on every cycle:
- When the qualification stage is inactive, the counter stays frozen.
- The counter never steps by more than one when the threshold mask or edge detect is set.
- The interrupt request stays high until it is cleared.
- The interrupt request cannot rise while the interrupt enable is clear.
- A clear pulse without the enable leaves the request low.

Other behaviours can only be shown by the bench's sweeps, because they depend on exact sums over several cycles:
- the popcount under each unit mask
- the exact threshold and inversion results
- the single count per rising condition
- the privilege gating
- load priority
- the wrap value and the case where an overflow and a clear arrive in the same cycle

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int UMASK_W = 8;
    localparam int OCC_W   = $clog2(UMASK_W + 1);
    localparam logic [31:0] CFG_RESET = 32'h0041_0000;

    // Field layout follows the control word bit positions, MSB first.
    typedef struct packed {
        logic [7:0]         thr_mask;   // [31:24]
        logic               invert;     // [23]
        logic               glb_en;     // [22]
        logic               rsvd;       // [21]
        logic               irq_en;     // [20]
        logic               pin_ctl;    // [19]
        logic               edge_det;   // [18]
        logic               os_en;      // [17]
        logic               usr_en;     // [16]
        logic [UMASK_W-1:0] unit_mask;  // [15:8]
        logic [7:0]         evt_sel;    // [7:0]
    } evc_cfg_t;

    typedef enum logic {
        COND_LOW  = 1'b0,
        COND_HIGH = 1'b1
    } cond_state_e;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

endpackage

// File: rtl/evc_cfg_reg.sv
module evc_cfg_reg
    import evc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output evc_cfg_t    cfg
);

    evc_cfg_t wr_cfg;

    always_comb begin
        wr_cfg      = evc_cfg_t'(wr_data);
        wr_cfg.rsvd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= evc_cfg_t'(CFG_RESET);
        end else if (wr_en) begin
            cfg <= wr_cfg;
        end
    end

endmodule

// File: rtl/evc_qualify.sv
module evc_qualify
    import evc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [UMASK_W-1:0] sub_hits,
    input  logic [UMASK_W-1:0] unit_mask,
    input  logic [1:0]         priv,
    input  logic               usr_en,
    input  logic               os_en,
    input  logic               glb_en,
    output logic [OCC_W-1:0]   occ_q,
    output logic               ok_q
);

    logic [UMASK_W-1:0] masked;
    logic [OCC_W-1:0]   occ_sum;
    logic               priv_ok;

    assign masked = sub_hits & unit_mask;

    always_comb begin
        occ_sum = '0;
        for (int i = 0; i < UMASK_W; i++) begin
            occ_sum = occ_sum + OCC_W'(masked[i]);
        end
    end

    assign priv_ok = (priv == 2'd0) ? os_en : usr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            occ_q <= occ_sum;
            ok_q  <= priv_ok & glb_en;
        end
    end

endmodule

// File: rtl/evc_condition.sv
module evc_condition
    import evc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occ,
    input  logic             ok,
    input  logic [7:0]       thr_mask,
    input  logic             invert,
    input  logic             edge_det,
    output logic [OCC_W-1:0] inc
);

    cond_state_e state_q, state_d;
    logic        thr_on;
    logic        cmp_raw;
    logic        cond;

    assign thr_on  = (thr_mask != 8'd0);
    assign cmp_raw = thr_on ? ((8'(occ) >= thr_mask) ^ invert) : (occ != '0);
    assign cond    = ok & cmp_raw;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= COND_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: rise / fall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            COND_LOW:  if (cond)  state_d = COND_HIGH;
            COND_HIGH: if (!cond) state_d = COND_LOW;
            default:   state_d = COND_LOW;
        endcase
    end

    // Output: increment for this cycle
    always_comb begin
        inc = '0;
        if (ok) begin
            if (edge_det) begin
                unique case (state_q)
                    COND_LOW:  inc = cond ? OCC_W'(1) : '0;
                    COND_HIGH: inc = '0;
                    default:   inc = '0;
                endcase
            end else if (thr_on) begin
                inc = cond ? OCC_W'(1) : '0;
            end else begin
                inc = occ;
            end
        end
    end

endmodule

// File: rtl/evc_accum.sv
module evc_accum
    import evc_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] inc,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    logic [CNT_W:0] sum;
    logic           wrap;
    irq_state_e     irq_q, irq_d;

    assign sum  = {1'b0, count} + {{(CNT_W + 1 - OCC_W){1'b0}}, inc};
    assign wrap = !load_en && sum[CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else begin
            count <= sum[CNT_W-1:0];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= IRQ_IDLE;
        end else begin
            irq_q <= irq_d;
        end
    end

    // Next state: raise / clear, raise wins
    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_IDLE:    if (wrap && irq_en) irq_d = IRQ_PENDING;
            IRQ_PENDING: if (irq_clr && !(wrap && irq_en)) irq_d = IRQ_IDLE;
            default:     irq_d = IRQ_IDLE;
        endcase
    end

    // Output
    always_comb begin
        unique case (irq_q)
            IRQ_PENDING: irq = 1'b1;
            default:     irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/evc_counter_top.sv
module evc_counter_top
    import evc_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_q,
    input  logic [7:0]       sub_hits,
    input  logic [1:0]       priv,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] count,
    input  logic             irq_clr,
    output logic             irq
);

    evc_cfg_t         cfg;
    logic [OCC_W-1:0] qual_occ;
    logic             qual_ok;
    logic [OCC_W-1:0] step;

    evc_cfg_reg cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    assign cfg_q = cfg;

    evc_qualify qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_hits  (sub_hits),
        .unit_mask (cfg.unit_mask),
        .priv      (priv),
        .usr_en    (cfg.usr_en),
        .os_en     (cfg.os_en),
        .glb_en    (cfg.glb_en),
        .occ_q     (qual_occ),
        .ok_q      (qual_ok)
    );

    evc_condition cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .occ      (qual_occ),
        .ok       (qual_ok),
        .thr_mask (cfg.thr_mask),
        .invert   (cfg.invert),
        .edge_det (cfg.edge_det),
        .inc      (step)
    );

    evc_accum #(.CNT_W(CNT_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (step),
        .load_en  (cnt_we),
        .load_val (cnt_wdata),
        .irq_en   (cfg.irq_en),
        .irq_clr  (irq_clr),
        .count    (count),
        .irq      (irq)
    );

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      cfg_q,
    input logic             cnt_we,
    input logic             irq_clr,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             qual_ok
);

    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual_ok && !cnt_we) |=> $stable(count));

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[31:24] != 8'd0 && !cnt_we) |=> ((count - $past(count)) <= 1));

    a_r7_edge_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[18] && !cnt_we) |=> ((count - $past(count)) <= 1));

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    a_r10_no_irq_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !cfg_q[20]) |=> !irq);

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cfg_q[20]) |=> !irq);

endmodule

bind evc_counter_top evc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_q   (cfg_q),
    .cnt_we  (cnt_we),
    .irq_clr (irq_clr),
    .count   (count),
    .irq     (irq),
    .qual_ok (qual_ok)
);

// File: tb/evc_counter_top_tb_top.sv
module evc_counter_top_tb_top;

    localparam int CNT_W = 40;
    localparam int RUN_L = 5;
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_q;
    logic [7:0]       sub_hits = '0;
    logic [1:0]       priv = '0;
    logic             cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic [CNT_W-1:0] count;
    logic             irq_clr = 1'b0;
    logic             irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    evc_counter_top #(.CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .sub_hits  (sub_hits),
        .priv      (priv),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .count     (count),
        .irq_clr   (irq_clr),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input logic [7:0] um, input logic [7:0] thr,
                                           input bit inv, input bit edg, input bit usr,
                                           input bit os, input bit en, input bit ien);
        return {thr, inv, en, 1'b0, ien, 1'b0, edg, os, usr, um, 8'h2C};
    endfunction

    task automatic setup(input logic [31:0] cw, input logic [CNT_W-1:0] preload,
                         input logic [1:0] idle_priv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = cw;
        cnt_we = 1'b1; cnt_wdata = preload;
        sub_hits = '0; priv = idle_priv;
        @(negedge clk);
        cfg_we = 1'b0; cnt_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic burst(input logic [7:0] hits, input logic [1:0] act_priv,
                         input logic [1:0] idle_priv, input int len);
        sub_hits = hits; priv = act_priv;
        repeat (len) @(negedge clk);
        sub_hits = '0; priv = idle_priv;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(input string req, input logic [31:0] cw, input logic [7:0] hits,
                            input logic [1:0] act_priv, input logic [1:0] idle_priv,
                            input logic [CNT_W-1:0] exp);
        setup(cw, '0, idle_priv);
        burst(hits, act_priv, idle_priv, RUN_L);
        check(req, 64'(count), 64'(exp));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cfg", 64'(cfg_q), 64'h0041_0000);
        check("R1 count", 64'(count), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: write all ones, reserved bit 21 reads 0
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); cfg_we = 1'b0;
        check("R2 all ones", 64'(cfg_q), 64'hFFDF_FFFF);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h5AA5_3C96;
        @(negedge clk); cfg_we = 1'b0;
        check("R2 pattern", 64'(cfg_q), 64'h5A85_3C96);

        // R3/R5/R6/R7 sweep: user only, idle privilege 0, active privilege 3
        for (int h = 0; h < 256; h += 17) begin
            for (int u = 0; u < 3; u++) begin
                logic [7:0] um;
                int pc;
                um = (u == 0) ? 8'hFF : ((u == 1) ? 8'h0F : 8'hA5);
                pc = $countones(8'(h) & um);
                // R3 R5: raw count, invert ignored when mask zero
                run_case("R3 raw", mk_cfg(um, 8'd0, 0, 0, 1, 0, 1, 0), 8'(h), 2'd3, 2'd0,
                         CNT_W'(RUN_L * pc));
                run_case("R5 raw invert", mk_cfg(um, 8'd0, 1, 0, 1, 0, 1, 0), 8'(h), 2'd3, 2'd0,
                         CNT_W'(RUN_L * pc));
                for (int t = 1; t <= 7; t += 3) begin
                    // R6: threshold and inverted threshold
                    run_case("R6 thr", mk_cfg(um, 8'(t), 0, 0, 1, 0, 1, 0), 8'(h), 2'd3, 2'd0,
                             (pc >= t) ? CNT_W'(RUN_L) : '0);
                    run_case("R6 thr inv", mk_cfg(um, 8'(t), 1, 0, 1, 0, 1, 0), 8'(h), 2'd3, 2'd0,
                             (pc < t) ? CNT_W'(RUN_L) : '0);
                    // R7: one count per rising condition
                    run_case("R7 edge thr", mk_cfg(um, 8'(t), 0, 1, 1, 0, 1, 0), 8'(h), 2'd3, 2'd0,
                             (pc >= t) ? CNT_W'(1) : '0);
                end
                run_case("R7 edge nz", mk_cfg(um, 8'd0, 0, 1, 1, 0, 1, 0), 8'(h), 2'd3, 2'd0,
                         (pc != 0) ? CNT_W'(1) : '0);
            end
        end

        // R7: two separate rises give two counts
        setup(mk_cfg(8'hFF, 8'd2, 0, 1, 1, 0, 1, 0), '0, 2'd0);
        burst(8'h07, 2'd1, 2'd0, 3);
        burst(8'h03, 2'd2, 2'd0, 2);
        check("R7 two rises", 64'(count), 64'd2);

        // R4: privilege gating
        for (int p = 0; p < 4; p++) begin
            run_case("R4 usr only", mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 1, 0), 8'h33, 2'(p), 2'd0,
                     (p != 0) ? CNT_W'(RUN_L * 4) : '0);
            run_case("R4 os only", mk_cfg(8'hFF, 8'd0, 0, 0, 0, 1, 1, 0), 8'h33, 2'(p), 2'd1,
                     (p == 0) ? CNT_W'(RUN_L * 4) : '0);
            run_case("R4 none", mk_cfg(8'hFF, 8'd0, 0, 0, 0, 0, 1, 0), 8'h33, 2'(p), 2'd0, '0);
        end

        // R8: freeze while global enable clear
        setup(mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 1, 0), CNT_W'(100), 2'd0);
        burst(8'h0F, 2'd3, 2'd0, 4);
        check("R8 before freeze", 64'(count), 64'd116);
        setup(mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 0, 0), CNT_W'(116), 2'd0);
        burst(8'hFF, 2'd3, 2'd3, 6);
        check("R8 frozen", 64'(count), 64'd116);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 1, 0);
        priv = 2'd0;
        @(negedge clk); cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        burst(8'h03, 2'd3, 2'd0, 2);
        check("R8 resumed", 64'(count), 64'd120);

        // R9: load wins over a concurrent increment
        setup(mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 1, 0), '0, 2'd0);
        sub_hits = 8'h07; priv = 2'd3;
        repeat (3) @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = CNT_W'(500);
        @(negedge clk);
        cnt_we = 1'b0; sub_hits = '0; priv = 2'd0;
        repeat (3) @(negedge clk);
        check("R9 load priority", 64'(count), 64'd503);

        // R10: wrap with interrupt enabled
        setup(mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 1, 1), TOP - CNT_W'(2), 2'd0);
        check("R10 no irq before wrap", 64'(irq), 64'd0);
        burst(8'h03, 2'd1, 2'd0, 2);
        check("R10 wrap value", 64'(count), 64'd1);
        check("R10 irq set", 64'(irq), 64'd1);
        repeat (5) @(negedge clk);
        check("R10 irq sticky", 64'(irq), 64'd1);

        // R11: clear pulse
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R11 cleared", 64'(irq), 64'd0);

        // R11: overflow and clear in the same cycle, overflow wins
        setup(mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 1, 1), TOP, 2'd0);
        sub_hits = 8'h01; priv = 2'd2;
        @(negedge clk);
        sub_hits = '0; priv = 2'd0; irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R11 set wins", 64'(irq), 64'd1);
        check("R11 wrap count", 64'(count), 64'd0);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // R10: wrap with interrupt disabled leaves irq low
        setup(mk_cfg(8'hFF, 8'd0, 0, 0, 1, 0, 1, 0), TOP - CNT_W'(1), 2'd0);
        burst(8'h0F, 2'd1, 2'd0, 1);
        check("R10 wrap disabled count", 64'(count), 64'd2);
        check("R10 wrap disabled irq", 64'(irq), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule